// File: doc/BRIEF.md
# I2C Bus Slave with General-Call Recognition

This block is the target side of a two-wire serial bus. It watches the open-drain clock (SCL) and data (SDA) lines and finds the start, repeated-start and stop conditions. It takes in the first byte after every start as seven address bits followed by a direction bit. It answers with an acknowledge when the address equals its programmed 7-bit address, or when the byte is the general-call value. Either kind of match raises a sticky interrupt. Status bits report which kind of address matched.

A write direction puts the block in receive mode. It acknowledges every following byte and keeps the last one for the host. A read direction puts it in transmit mode. It shifts out the host's data byte, most significant bit first, and reloads that byte each time the master acknowledges. After a not-acknowledge from the master it lets go of SDA and waits for the next start.

The host side is a small register port. It holds the own address, the transmit and receive data, and a status byte, and a write to the status location clears the interrupt. The block drives SDA only through an output enable, which pulls the line low when set. It never drives SCL.

Top module: `i2c_gc_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) restarts address reception from any state, including part way through a byte. A STOP (SDA rising while SCL is high) returns the block to idle. Both release SDA.
- R2: The first byte after every START is sampled on SCL rising edges, MSB first. Its upper seven bits are the address and bit 0 is the direction (1 = read).
- R3: The block acknowledges the address byte by pulling SDA low for the ninth clock when bits [7:1] equal the own address (either direction), or when the byte is 0x00 (general call). Any other byte, including 0x01, gets no acknowledge, and SDA stays released until the next START.
- R4: After a write address, every data byte is acknowledged. The byte is stored and can be read at host select 1.
- R5: After a read address, the byte in the transmit register (written at host select 1) is shifted out MSB first. The byte is taken at the SCL fall that ends the address acknowledge, and again at the fall that ends each master acknowledge.
- R6: sda_oe changes only in response to an SCL falling edge or a START/STOP. It never changes while SCL is high.
- R7: In transmit mode a master not-acknowledge (SDA high in the ninth clock) makes the block release SDA. It drives nothing more until the next START.
- R8: A repeated START puts the block back into address matching. The new address byte alone decides whether it acknowledges.
- R9: Status (host select 2) bits: [0] own-address match, [1] general-call match, [2] direction (1 = transmit), [3] last master acknowledge (1 = ACK), [4] STOP seen while addressed, [5] repeated START seen while addressed, [6] currently addressed, [7] interrupt.
- R10: irq is set by an address match, a received byte, a master acknowledge slot in transmit mode, or a STOP or repeated START while addressed. irq stays set until a host write to select 2, which also clears status bits [4] and [5].
- R11: Host select 0 holds the 7-bit own address. Its reset value is the parameter RESET_ADDR, and a host write replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Host register select: 0 address, 1 data, 2 status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the selected register |
| irq | output | 1 | Sticky interrupt request |

## Verification
The bench builds the block with SYNC_STAGES set to 3 and RESET_ADDR set to 0x3C. The extra synchroniser stage delays every line event by one more cycle, so the per-clock comparison of sda_oe during every SCL high phase shows that the output still settles inside the low phase. The non-zero reset address, later reprogrammed to 0x51, keeps the own address apart from the general-call value. This lets 0x00 and 0x01 test general-call acceptance and refusal on their own. Repeated and mid-byte STARTs, a mid-byte STOP, and a read that runs past the master's not-acknowledge cover the release and re-entry paths.

// File: rtl/i2c_gc_pkg.sv
package i2c_gc_pkg;
  parameter int unsigned I2C_ADDR_W = 7;
  parameter int unsigned I2C_BYTE_W = 8;
  parameter int unsigned HOST_SEL_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,  // bus free or not yet started
    ST_ADDR,  // shifting in address + direction
    ST_AACK,  // driving address acknowledge
    ST_RX,    // shifting in a data byte
    ST_RACK,  // driving data acknowledge
    ST_TX,    // shifting out a data byte
    ST_TACK,  // master acknowledge slot
    ST_SKIP   // released until next START
  } eng_state_t;

  // bits [7:1] of an address byte against the programmed address
  function automatic logic addr_is_own(input logic [I2C_BYTE_W-1:0] b,
                                       input logic [I2C_ADDR_W-1:0] own);
    return b[I2C_BYTE_W-1:1] == own;
  endfunction

  // general call: all-zero address with write direction
  function automatic logic addr_is_gcall(input logic [I2C_BYTE_W-1:0] b);
    return b == '0;
  endfunction
endpackage

// File: rtl/i2c_gc_sync.sv
module i2c_gc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int unsigned LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] tap;
  logic [LINES-1:0] prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign tap[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= tap;
  end

  assign scl_s    = tap[1];
  assign sda_s    = tap[0];
  assign scl_rise =  tap[1] & ~prev[1];
  assign scl_fall = ~tap[1] &  prev[1];
  assign start_ev =  tap[1] &  prev[1] &  prev[0] & ~tap[0];
  assign stop_ev  =  tap[1] &  prev[1] & ~prev[0] &  tap[0];
endmodule

// File: rtl/i2c_gc_engine.sv
module i2c_gc_engine
  import i2c_gc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_s,
  input  logic                  sda_s,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic                  start_ev,
  input  logic                  stop_ev,
  input  logic [I2C_ADDR_W-1:0] own_addr,
  input  logic [I2C_BYTE_W-1:0] tx_byte,
  output logic                  sda_oe,
  output logic                  selected,
  output logic                  ev_match,
  output logic                  m_own,
  output logic                  m_gc,
  output logic                  dir_rd,
  output logic                  ev_rx,
  output logic [I2C_BYTE_W-1:0] rx_byte,
  output logic                  ev_tack,
  output logic                  ack_seen,
  output logic                  ev_stop,
  output logic                  ev_rs
);
  localparam int unsigned CNT_W = $clog2(I2C_BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(I2C_BYTE_W);

  eng_state_t            state;
  logic [CNT_W-1:0]      bit_cnt;
  logic [I2C_BYTE_W-1:0] sh;
  logic                  hit_own, hit_gc;

  assign hit_own = addr_is_own(sh, own_addr);
  assign hit_gc  = addr_is_gcall(sh);
  assign rx_byte = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      sh       <= '0;
      sda_oe   <= 1'b0;
      selected <= 1'b0;
      ev_match <= 1'b0;
      m_own    <= 1'b0;
      m_gc     <= 1'b0;
      dir_rd   <= 1'b0;
      ev_rx    <= 1'b0;
      ev_tack  <= 1'b0;
      ack_seen <= 1'b0;
      ev_stop  <= 1'b0;
      ev_rs    <= 1'b0;
    end else begin
      ev_match <= 1'b0;
      ev_rx    <= 1'b0;
      ev_tack  <= 1'b0;
      ev_stop  <= 1'b0;
      ev_rs    <= 1'b0;
      if (start_ev) begin
        ev_rs    <= selected;
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        sda_oe   <= 1'b0;
        selected <= 1'b0;
      end else if (stop_ev) begin
        ev_stop  <= selected;
        state    <= ST_IDLE;
        sda_oe   <= 1'b0;
        selected <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise && bit_cnt < CNT_FULL) begin
              sh      <= {sh[I2C_BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == CNT_FULL) begin
              if (hit_own || hit_gc) begin
                state    <= ST_AACK;
                sda_oe   <= 1'b1;
                selected <= 1'b1;
                ev_match <= 1'b1;
                m_own    <= hit_own;
                m_gc     <= hit_gc;
                dir_rd   <= sh[0];
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (dir_rd) begin
                state  <= ST_TX;
                sh     <= tx_byte;
                sda_oe <= ~tx_byte[I2C_BYTE_W-1];
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_RX: begin
            if (scl_rise && bit_cnt < CNT_FULL) begin
              sh      <= {sh[I2C_BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == CNT_FULL) begin
              state  <= ST_RACK;
              sda_oe <= 1'b1;
              ev_rx  <= 1'b1;
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              state   <= ST_RX;
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
            end
          end
          ST_TX: begin
            if (scl_rise && bit_cnt < CNT_FULL) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt == CNT_FULL) begin
                state  <= ST_TACK;
                sda_oe <= 1'b0;
              end else begin
                sh     <= sh << 1;
                sda_oe <= ~sh[I2C_BYTE_W-2];
              end
            end
          end
          ST_TACK: begin
            if (scl_rise) begin
              ack_seen <= ~sda_s;
              ev_tack  <= 1'b1;
            end else if (scl_fall) begin
              if (ack_seen) begin
                state   <= ST_TX;
                bit_cnt <= '0;
                sh      <= tx_byte;
                sda_oe  <= ~tx_byte[I2C_BYTE_W-1];
              end else begin
                state  <= ST_SKIP;
                sda_oe <= 1'b0;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  // R6: the data line is pulled low only after an SCL falling edge
  a_r6_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));
  // R6 / R1: release comes from an SCL fall or a bus condition
  a_r6_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(scl_fall || start_ev || stop_ev));
  // R6: no output change across a sustained SCL high phase
  a_r6_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_ev || stop_ev)) |-> $stable(sda_oe));
  // R1: a START restarts the bit count
  a_r1_start_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (bit_cnt == '0));
  // R2: never more than one byte's worth of bits counted
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_FULL);
endmodule

// File: rtl/i2c_gc_regs.sv
module i2c_gc_regs
  import i2c_gc_pkg::*;
#(
  parameter logic [I2C_ADDR_W-1:0] RESET_ADDR = 7'h2A
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_we,
  input  logic [HOST_SEL_W-1:0] host_sel,
  input  logic [I2C_BYTE_W-1:0] host_wdata,
  output logic [I2C_BYTE_W-1:0] host_rdata,
  output logic                  irq,
  output logic [I2C_ADDR_W-1:0] own_addr,
  output logic [I2C_BYTE_W-1:0] tx_byte,
  input  logic                  selected,
  input  logic                  ev_match,
  input  logic                  m_own,
  input  logic                  m_gc,
  input  logic                  dir_rd,
  input  logic                  ev_rx,
  input  logic [I2C_BYTE_W-1:0] rx_byte,
  input  logic                  ev_tack,
  input  logic                  ack_seen,
  input  logic                  ev_stop,
  input  logic                  ev_rs
);
  localparam logic [HOST_SEL_W-1:0] SEL_ADDR = 2'd0;
  localparam logic [HOST_SEL_W-1:0] SEL_DATA = 2'd1;
  localparam logic [HOST_SEL_W-1:0] SEL_STAT = 2'd2;

  logic [I2C_BYTE_W-1:0] rx_q;
  logic st_own, st_gc, st_dir, st_ack, st_stop, st_rs;
  logic clr, any_ev;

  assign clr    = host_we && (host_sel == SEL_STAT);
  assign any_ev = ev_match | ev_rx | ev_tack | ev_stop | ev_rs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_addr <= RESET_ADDR;
      tx_byte  <= '0;
      rx_q     <= '0;
      {st_own, st_gc, st_dir, st_ack, st_stop, st_rs} <= '0;
      irq      <= 1'b0;
    end else begin
      if (host_we && host_sel == SEL_ADDR) own_addr <= host_wdata[I2C_ADDR_W-1:0];
      if (host_we && host_sel == SEL_DATA) tx_byte  <= host_wdata;
      if (clr) begin
        irq     <= 1'b0;
        st_stop <= 1'b0;
        st_rs   <= 1'b0;
      end
      if (ev_match) begin
        st_own <= m_own;
        st_gc  <= m_gc;
        st_dir <= dir_rd;
      end
      if (ev_rx)   rx_q    <= rx_byte;
      if (ev_tack) st_ack  <= ack_seen;
      if (ev_stop) st_stop <= 1'b1;
      if (ev_rs)   st_rs   <= 1'b1;
      if (any_ev)  irq     <= 1'b1;
    end
  end

  always_comb begin
    unique case (host_sel)
      SEL_ADDR: host_rdata = {1'b0, own_addr};
      SEL_DATA: host_rdata = rx_q;
      SEL_STAT: host_rdata = {irq, selected, st_rs, st_stop, st_ack, st_dir, st_gc, st_own};
      default:  host_rdata = '0;
    endcase
  end

  // R10: the interrupt holds until the host clears it
  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);
  // R10: the interrupt only rises because of a bus event
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(any_ev));
endmodule

// File: rtl/i2c_gc_slave.sv
module i2c_gc_slave
  import i2c_gc_pkg::*;
#(
  parameter logic [I2C_ADDR_W-1:0] RESET_ADDR  = 7'h2A,
  parameter int unsigned           SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic                  host_we,
  input  logic [HOST_SEL_W-1:0] host_sel,
  input  logic [I2C_BYTE_W-1:0] host_wdata,
  output logic [I2C_BYTE_W-1:0] host_rdata,
  output logic                  irq
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [I2C_ADDR_W-1:0] own_addr;
  logic [I2C_BYTE_W-1:0] tx_byte, rx_byte;
  logic selected, ev_match, m_own, m_gc, dir_rd, ev_rx, ev_tack, ack_seen, ev_stop, ev_rs;

  i2c_gc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_gc_engine u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .own_addr(own_addr), .tx_byte(tx_byte), .sda_oe(sda_oe), .selected(selected),
    .ev_match(ev_match), .m_own(m_own), .m_gc(m_gc), .dir_rd(dir_rd),
    .ev_rx(ev_rx), .rx_byte(rx_byte), .ev_tack(ev_tack), .ack_seen(ack_seen),
    .ev_stop(ev_stop), .ev_rs(ev_rs)
  );

  i2c_gc_regs #(.RESET_ADDR(RESET_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
    .own_addr(own_addr), .tx_byte(tx_byte), .selected(selected),
    .ev_match(ev_match), .m_own(m_own), .m_gc(m_gc), .dir_rd(dir_rd),
    .ev_rx(ev_rx), .rx_byte(rx_byte), .ev_tack(ev_tack), .ack_seen(ack_seen),
    .ev_stop(ev_stop), .ev_rs(ev_rs)
  );
endmodule

// File: tb/tb_i2c_gc_slave.sv
`timescale 1ns/1ps
module tb_i2c_gc_slave;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, irq;
  logic host_we = 1'b0;
  logic [1:0] host_sel = 2'd0;
  logic [7:0] host_wdata = 8'h00, host_rdata;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;  // open-drain wired-AND

  i2c_gc_slave #(.RESET_ADDR(7'h3C), .SYNC_STAGES(3)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq)
  );

  int vectors = 0;
  int miscompares = 0;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    host_sel = sel;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [1:0] sel, input logic [7:0] exp);
    logic [7:0] v;
    host_read(sel, v);
    chk(req, v, exp);
  endtask

  // one bus clock; sda_oe compared against the model on every clock of the high phase
  task automatic xbit(input logic mb, input logic exp_low, input string req, output logic seen);
    sda_m = mb;
    wait_clk(6);
    scl_m = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(req, sda_oe, exp_low);
      if (k == 4) seen = sda_line;
    end
    scl_m = 1'b0;
    wait_clk(2);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(6);
    scl_m = 1'b1; wait_clk(6);
    sda_m = 1'b0; wait_clk(6);
    scl_m = 1'b0; wait_clk(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(6);
    scl_m = 1'b1; wait_clk(6);
    sda_m = 1'b1; wait_clk(6);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) xbit(b[i], 1'b0, "R6", s);
    xbit(1'b1, exp_ack, req, s);
    chk(req, s, exp_ack ? 0 : 1);
  endtask

  task automatic read_byte(input logic [7:0] exp, input logic mack,
                           input logic [7:0] next, input string req);
    logic s;
    logic [7:0] got = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      if (i == 3) host_write(2'd1, next);
      xbit(1'b1, ~exp[i], "R5", s);
      got = {got[6:0], s};
    end
    xbit(~mack, 1'b0, "R6", s);
    chk(req, got, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic s;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);

    // reset state
    chk("R11 reset addr", 0, 0);
    chk_reg("R11 reset addr", 2'd0, 8'h3C);
    chk_reg("R9 reset status", 2'd2, 8'h00);
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R10 reset irq", irq, 0);

    host_write(2'd0, 8'h51);
    chk_reg("R11 addr write", 2'd0, 8'h51);

    // write transfer to own address
    bus_start();
    send_byte(8'hA2, 1'b1, "R3 own write ack");
    chk_reg("R9 own match status", 2'd2, 8'hC1);
    host_write(2'd2, 8'h00);
    chk("R10 irq cleared", irq, 0);
    send_byte(8'h3C, 1'b1, "R4 data ack");
    chk_reg("R4 rx byte", 2'd1, 8'h3C);
    chk("R10 irq on rx", irq, 1);
    host_write(2'd2, 8'h00);
    send_byte(8'hC5, 1'b1, "R4 data ack 2");
    chk_reg("R4 rx byte 2", 2'd1, 8'hC5);
    host_write(2'd2, 8'h00);
    bus_stop();
    chk("R1 stop releases", sda_oe, 0);
    chk_reg("R10 stop status", 2'd2, 8'h91);
    host_write(2'd2, 8'h00);
    chk_reg("R10 clear bits", 2'd2, 8'h01);

    // other address: ignored
    bus_start();
    send_byte(8'h40, 1'b0, "R3 foreign nack");
    send_byte(8'h55, 1'b0, "R3 stays released");
    bus_stop();
    chk("R3 no irq", irq, 0);
    chk_reg("R3 rx untouched", 2'd1, 8'hC5);
    chk_reg("R3 status untouched", 2'd2, 8'h01);

    // general call
    bus_start();
    send_byte(8'h00, 1'b1, "R3 gcall ack");
    chk_reg("R9 gcall status", 2'd2, 8'hC2);
    host_write(2'd2, 8'h00);
    send_byte(8'h77, 1'b1, "R4 gcall data");
    chk_reg("R4 gcall rx", 2'd1, 8'h77);
    bus_stop();
    chk_reg("R9 gcall stop", 2'd2, 8'h92);
    host_write(2'd2, 8'h00);

    // general call address with read bit: refused
    bus_start();
    send_byte(8'h01, 1'b0, "R3 gcall read nack");
    bus_stop();
    chk("R3 gcall read no irq", irq, 0);

    // read transfer
    host_write(2'd1, 8'h96);
    bus_start();
    send_byte(8'hA3, 1'b1, "R3 own read ack");
    chk_reg("R9 read status", 2'd2, 8'hC5);
    host_write(2'd2, 8'h00);
    read_byte(8'h96, 1'b1, 8'h3E, "R5 first tx byte");
    chk_reg("R9 master ack status", 2'd2, 8'hCD);
    host_write(2'd2, 8'h00);
    read_byte(8'h3E, 1'b0, 8'hAA, "R5 second tx byte");
    chk_reg("R7 master nack status", 2'd2, 8'hC5);
    host_write(2'd2, 8'h00);
    begin
      logic [7:0] got = 8'h00;
      for (int i = 0; i < 8; i++) begin
        xbit(1'b1, 1'b0, "R7 released after nack", s);
        got = {got[6:0], s};
      end
      chk("R7 line idle after nack", got, 8'hFF);
    end
    bus_stop();
    chk_reg("R7 stop after read", 2'd2, 8'h95);
    host_write(2'd2, 8'h00);

    // repeated start during receive
    bus_start();
    send_byte(8'hA2, 1'b1, "R8 first addr");
    host_write(2'd2, 8'h00);
    send_byte(8'h11, 1'b1, "R8 data before rs");
    chk_reg("R8 rx before rs", 2'd1, 8'h11);
    host_write(2'd2, 8'h00);
    bus_start();
    chk_reg("R8 rs status", 2'd2, 8'hA1);
    send_byte(8'h00, 1'b1, "R8 gcall after rs");
    chk_reg("R8 new match status", 2'd2, 8'hE2);
    host_write(2'd2, 8'h00);
    send_byte(8'h22, 1'b1, "R8 data after rs");
    chk_reg("R8 rx after rs", 2'd1, 8'h22);
    host_write(2'd2, 8'h00);
    bus_start();
    chk_reg("R8 second rs status", 2'd2, 8'hA2);
    send_byte(8'h40, 1'b0, "R8 foreign after rs");
    bus_stop();
    chk_reg("R8 no stop flag unaddressed", 2'd2, 8'hA2);
    host_write(2'd2, 8'h00);

    // START part way through a byte
    bus_start();
    send_byte(8'hA2, 1'b1, "R1 addr before break");
    xbit(1'b1, 1'b0, "R1 partial", s);
    xbit(1'b0, 1'b0, "R1 partial", s);
    xbit(1'b1, 1'b0, "R1 partial", s);
    bus_start();
    send_byte(8'hA2, 1'b1, "R1 addr after mid-byte start");
    send_byte(8'h5D, 1'b1, "R1 data after mid-byte start");
    chk_reg("R1 rx after mid-byte start", 2'd1, 8'h5D);
    bus_stop();
    host_write(2'd2, 8'h00);

    // STOP part way through a byte
    bus_start();
    send_byte(8'hA2, 1'b1, "R1 addr before stop");
    for (int i = 0; i < 4; i++) xbit(1'b0, 1'b0, "R1 partial", s);
    bus_stop();
    chk("R1 mid-byte stop release", sda_oe, 0);
    chk_reg("R1 mid-byte stop status", 2'd2, 8'h91);
    chk_reg("R1 rx unchanged", 2'd1, 8'h5D);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule